// File: doc/BRIEF.md
# Three-Segment Gamma Curve Evaluator

This block applies a piecewise-linear transfer curve to one colour channel. The input is an unsigned fixed-point fraction with 18 fractional bits. One extra integer bit lets the value 1.0 and anything above it be presented. The curve is held in three nested tables, and each has a different step size. A superfine table resolves the darkest few codes at full input resolution. A fine table covers the low end of the range. A coarse table covers the whole range up to 1.0. A table entry is 16 bits wide, so it cannot hold 1.0. A separate maximum register gives the result for any input at or above 1.0.

The block chooses a segment from the input value. It reads the two neighbouring entries of that segment and interpolates linearly between them, using the low input bits as the weight. The result appears a fixed two cycles later, together with a valid flag. The tables are loaded through a simple synchronous write port. A full colour pipe places one instance per channel.

Top module: `gamma3_curve`

## Requirements
- R1: For an input below 8 (in units of 2^-18), the output equals superfine entry `x` exactly. Superfine steps are one input code wide, so the weight is zero.
- R2: For an input from 8 up to and including 2047, the fine table is used. The lower index is `x>>3` and the 3-bit weight is `x & 7`.
- R3: For an input from 2048 up to and including 2^18-1, the coarse table is used. The lower index is `x>>10` and the 10-bit weight is `x & 1023`.
- R4: The output is `lo + floor((hi-lo)*w / 2^wb)`, where `wb` is the weight width of the segment. Rounding is toward minus infinity, including on falling curves. The output always lies between `lo` and `hi`.
- R5: Any input with bit 18 set (1.0 or more) returns the maximum register, whatever the low bits are.
- R6: `valid_o` repeats `valid_i` from two rising edges earlier. `y_o` belongs to the input that was sampled at that same edge.
- R7: `wr_tbl_i` selects the target of a write: 0 superfine, 1 fine, 2 coarse, 3 maximum register. The table depths are 9, 257 and 257. A write to an address at or beyond the depth is ignored and changes no entry. A write to the maximum register ignores `wr_addr_i`. A write counts for inputs that are sampled on later edges.
- R8: After reset, `valid_o` and `y_o` are 0 and the maximum register holds 0.
- R9: The top entry of each table (fine 256, coarse 256) is the upper neighbour for the last interval of that table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Input sample valid |
| x_i | input | 19 | Input fraction: bit 18 is the integer part, bits 17:0 the fraction |
| wr_en_i | input | 1 | Table write strobe |
| wr_tbl_i | input | 2 | Write target: 0 superfine, 1 fine, 2 coarse, 3 maximum |
| wr_addr_i | input | 9 | Entry address within the target table |
| wr_data_i | input | 16 | Entry value |
| valid_o | output | 1 | Output valid, two cycles after `valid_i` |
| y_o | output | 16 | Corrected value |

## Verification
A sample is captured at one rising edge into the stage that reads the tables. It leaves the interpolation register at the next edge, so its result is due at the falling edge two cycles after it was driven. The bench drives inputs on falling edges and keeps a two-deep queue of expected values and valid flags. At every falling edge it compares the outputs with the entry queued two drives earlier, back to back with no gaps. Writes go in only after the queue has drained, so each expected value is computed from the table contents that the design sees at capture.

// File: rtl/gamma3_pkg.sv
package gamma3_pkg;
  typedef enum logic [1:0] {
    SEG_SUPER  = 2'd0,
    SEG_FINE   = 2'd1,
    SEG_COARSE = 2'd2,
    SEG_MAX    = 2'd3
  } seg_e;
endpackage

// File: rtl/gamma3_decode.sv
module gamma3_decode
  import gamma3_pkg::*;
#(
  parameter int FRAC_W = 18,
  parameter int SF_IDX = 3,
  parameter int FN_IDX = 8,
  parameter int CO_IDX = 8,
  parameter int IDX_W  = 8,
  parameter int WGT_W  = 10
) (
  input  logic [FRAC_W:0]  x_i,
  output seg_e             seg_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [WGT_W-1:0] wgt_o
);
  localparam int CO_STEP = FRAC_W - CO_IDX;
  localparam logic [FRAC_W-1:0] SF_SPAN = FRAC_W'(1) << SF_IDX;
  localparam logic [FRAC_W-1:0] FN_SPAN = FRAC_W'(1) << (SF_IDX + FN_IDX);

  logic [FRAC_W-1:0] frac;
  assign frac = x_i[FRAC_W-1:0];

  always_comb begin
    seg_o = SEG_COARSE;
    idx_o = '0;
    wgt_o = '0;
    if (x_i[FRAC_W]) begin
      seg_o = SEG_MAX;
    end else if (frac < SF_SPAN) begin
      seg_o = SEG_SUPER;
      idx_o = IDX_W'(frac[SF_IDX-1:0]);
    end else if (frac < FN_SPAN) begin
      seg_o = SEG_FINE;
      idx_o = IDX_W'(frac[SF_IDX+FN_IDX-1:SF_IDX]);
      // left-align the weight so one shift serves every segment
      wgt_o = WGT_W'(frac[SF_IDX-1:0]) << (WGT_W - SF_IDX);
    end else begin
      idx_o = IDX_W'(frac[FRAC_W-1:CO_STEP]);
      wgt_o = WGT_W'(frac[CO_STEP-1:0]) << (WGT_W - CO_STEP);
    end
  end
endmodule

// File: rtl/gamma3_bank.sv
module gamma3_bank #(
  parameter int DEPTH = 257,
  parameter int AW    = 9,
  parameter int DW    = 16,
  localparam int BW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] wa_i,
  input  logic [DW-1:0] wd_i,
  input  logic [BW-1:0] ra_i,
  output logic [DW-1:0] lo_o,
  output logic [DW-1:0] hi_o
);
  localparam logic [AW:0] DEPTH_L = (AW+1)'(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [BW-1:0] ra_next;
  logic          wa_ok;

  assign wa_ok   = {1'b0, wa_i} < DEPTH_L;
  assign ra_next = ra_i + BW'(1);

  always_ff @(posedge clk_i) begin
    if (we_i && wa_ok) mem[wa_i[BW-1:0]] <= wd_i;
  end

  assign lo_o = mem[ra_i];
  assign hi_o = mem[ra_next];
endmodule

// File: rtl/gamma3_tables.sv
module gamma3_tables
  import gamma3_pkg::*;
#(
  parameter int OUT_W  = 16,
  parameter int SF_IDX = 3,
  parameter int FN_IDX = 8,
  parameter int CO_IDX = 8,
  parameter int IDX_W  = 8,
  parameter int ADDR_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  seg_e              wr_tbl_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [OUT_W-1:0]  wr_data_i,
  input  seg_e              rd_seg_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [OUT_W-1:0]  lo_o,
  output logic [OUT_W-1:0]  hi_o,
  output logic [OUT_W-1:0]  max_o
);
  logic [OUT_W-1:0] lo_t [3];
  logic [OUT_W-1:0] hi_t [3];
  logic [OUT_W-1:0] max_q;

  for (genvar t = 0; t < 3; t++) begin : g_bank
    localparam int DEP = (t == 0) ? (2**SF_IDX + 1) :
                         (t == 1) ? (2**FN_IDX + 1) : (2**CO_IDX + 1);
    localparam int BWT = $clog2(DEP);
    gamma3_bank #(.DEPTH(DEP), .AW(ADDR_W), .DW(OUT_W)) i_bank (
      .clk_i (clk_i),
      .we_i  (wr_en_i && (wr_tbl_i == seg_e'(t))),
      .wa_i  (wr_addr_i),
      .wd_i  (wr_data_i),
      .ra_i  (BWT'(rd_idx_i)),
      .lo_o  (lo_t[t]),
      .hi_o  (hi_t[t])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              max_q <= '0;
    else if (wr_en_i && wr_tbl_i == SEG_MAX)  max_q <= wr_data_i;
  end

  always_comb begin
    unique case (rd_seg_i)
      SEG_SUPER:  begin lo_o = lo_t[0]; hi_o = hi_t[0]; end
      SEG_FINE:   begin lo_o = lo_t[1]; hi_o = hi_t[1]; end
      SEG_COARSE: begin lo_o = lo_t[2]; hi_o = hi_t[2]; end
      default:    begin lo_o = max_q;   hi_o = max_q;   end
    endcase
  end

  assign max_o = max_q;
endmodule

// File: rtl/gamma3_lerp.sv
module gamma3_lerp #(
  parameter int OUT_W = 16,
  parameter int WGT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             v_i,
  input  logic [OUT_W-1:0] lo_i,
  input  logic [OUT_W-1:0] hi_i,
  input  logic [WGT_W-1:0] wgt_i,
  output logic             v_o,
  output logic [OUT_W-1:0] y_o
);
  localparam int PW = OUT_W + WGT_W + 2;

  logic signed [OUT_W:0] diff;
  logic signed [WGT_W:0] wsg;
  logic signed [PW-1:0]  prod;
  logic signed [PW-1:0]  step;
  logic [OUT_W-1:0]      y_d;

  assign diff = $signed({1'b0, hi_i}) - $signed({1'b0, lo_i});
  assign wsg  = $signed({1'b0, wgt_i});
  assign prod = PW'(diff) * PW'(wsg);
  assign step = prod >>> WGT_W;  // arithmetic shift: floor toward -inf
  assign y_d  = OUT_W'(PW'($signed({1'b0, lo_i})) + step);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_o <= 1'b0;
      y_o <= '0;
    end else begin
      v_o <= v_i;
      y_o <= y_d;
    end
  end
endmodule

// File: rtl/gamma3_curve.sv
module gamma3_curve
  import gamma3_pkg::*;
#(
  parameter int FRAC_W = 18,
  parameter int OUT_W  = 16,
  parameter int SF_IDX = 3,
  parameter int FN_IDX = 8,
  parameter int CO_IDX = 8,
  parameter int ADDR_W = 9,
  localparam int IDX_W = (FN_IDX > CO_IDX) ? FN_IDX : CO_IDX,
  localparam int WGT_W = ((FRAC_W - CO_IDX) > SF_IDX) ? (FRAC_W - CO_IDX) : SF_IDX
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [FRAC_W:0]   x_i,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_tbl_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [OUT_W-1:0]  wr_data_i,
  output logic              valid_o,
  output logic [OUT_W-1:0]  y_o
);
  seg_e             seg_d, seg_q;
  logic [IDX_W-1:0] idx_d;
  logic [WGT_W-1:0] wgt_d, wgt_q;
  logic [OUT_W-1:0] lo_d, hi_d, lo_q, hi_q, max_w;
  logic             v1_q;

  gamma3_decode #(
    .FRAC_W(FRAC_W), .SF_IDX(SF_IDX), .FN_IDX(FN_IDX),
    .CO_IDX(CO_IDX), .IDX_W(IDX_W), .WGT_W(WGT_W)
  ) i_decode (
    .x_i   (x_i),
    .seg_o (seg_d),
    .idx_o (idx_d),
    .wgt_o (wgt_d)
  );

  gamma3_tables #(
    .OUT_W(OUT_W), .SF_IDX(SF_IDX), .FN_IDX(FN_IDX),
    .CO_IDX(CO_IDX), .IDX_W(IDX_W), .ADDR_W(ADDR_W)
  ) i_tables (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_tbl_i  (seg_e'(wr_tbl_i)),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .rd_seg_i  (seg_d),
    .rd_idx_i  (idx_d),
    .lo_o      (lo_d),
    .hi_o      (hi_d),
    .max_o     (max_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v1_q  <= 1'b0;
      seg_q <= SEG_SUPER;
      lo_q  <= '0;
      hi_q  <= '0;
      wgt_q <= '0;
    end else begin
      v1_q  <= valid_i;
      seg_q <= seg_d;
      lo_q  <= lo_d;
      hi_q  <= hi_d;
      wgt_q <= wgt_d;
    end
  end

  gamma3_lerp #(.OUT_W(OUT_W), .WGT_W(WGT_W)) i_lerp (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .v_i    (v1_q),
    .lo_i   (lo_q),
    .hi_i   (hi_q),
    .wgt_i  (wgt_q),
    .v_o    (valid_o),
    .y_o    (y_o)
  );
endmodule

// File: rtl/gamma3_chk.sv
module gamma3_chk
  import gamma3_pkg::*;
#(
  parameter int FRAC_W = 18,
  parameter int OUT_W  = 16,
  parameter int SF_IDX = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic [FRAC_W:0]  x_i,
  input logic             wr_en_i,
  input logic             valid_o,
  input logic [OUT_W-1:0] y_o,
  input logic             v1_q,
  input seg_e             seg_q,
  input logic [OUT_W-1:0] lo_q,
  input logic [OUT_W-1:0] hi_q,
  input logic [OUT_W-1:0] max_w
);
  localparam logic [FRAC_W-1:0] SF_SPAN = FRAC_W'(1) << SF_IDX;

  logic [1:0] age_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             age_q <= '0;
    else if (age_q != 2'd2)  age_q <= age_q + 2'd1;
  end

  assert_valid_latency_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 2'd2) |-> (valid_o == $past(valid_i, 2)));

  assert_max_passthru_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 2'd2 && $past(valid_i && x_i[FRAC_W], 2) &&
     !$past(wr_en_i, 1) && !$past(wr_en_i, 2)) |-> (y_o == max_w));

  assert_bounded_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    v1_q |=> ((y_o >= $past(lo_q) && y_o <= $past(hi_q)) ||
              (y_o <= $past(lo_q) && y_o >= $past(hi_q))));

  assert_super_select_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !x_i[FRAC_W] && x_i[FRAC_W-1:0] < SF_SPAN) |=> (seg_q == SEG_SUPER));

  assert_super_exact_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (v1_q && seg_q == SEG_SUPER) |=> (y_o == $past(lo_q)));
endmodule

bind gamma3_curve gamma3_chk #(.FRAC_W(FRAC_W), .OUT_W(OUT_W), .SF_IDX(SF_IDX)) i_gamma3_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .valid_i (valid_i),
  .x_i     (x_i),
  .wr_en_i (wr_en_i),
  .valid_o (valid_o),
  .y_o     (y_o),
  .v1_q    (v1_q),
  .seg_q   (seg_q),
  .lo_q    (lo_q),
  .hi_q    (hi_q),
  .max_w   (max_w)
);

// File: tb/test_gamma3_curve.sv
module test_gamma3_curve;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [18:0] x_i = '0;
  logic        wr_en_i = 1'b0;
  logic [1:0]  wr_tbl_i = '0;
  logic [8:0]  wr_addr_i = '0;
  logic [15:0] wr_data_i = '0;
  logic        valid_o;
  logic [15:0] y_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int sf_m [9];
  int fn_m [257];
  int co_m [257];
  int max_m = 0;

  bit    p0_v = 0, p1_v = 0;
  int    p0_e = 0, p1_e = 0;
  string p0_t = "", p1_t = "";
  string force_tag = "";

  always #4 clk = ~clk;

  gamma3_curve i_gamma3_curve (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .x_i(x_i),
    .wr_en_i(wr_en_i), .wr_tbl_i(wr_tbl_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .valid_o(valid_o), .y_o(y_o)
  );

  function automatic int floor8(int n, int d);
    if (n >= 0) return n / d;
    return -((-n + d - 1) / d);
  endfunction

  function automatic int model(logic [18:0] x);
    int i, w, lo, hi;
    if (x[18]) return max_m;
    if (x < 8) return sf_m[x];
    if (x < 2048) begin
      i = int'(x) / 8; w = int'(x) % 8; lo = fn_m[i]; hi = fn_m[i+1];
      return lo + floor8((hi - lo) * w, 8);
    end
    i = int'(x) / 1024; w = int'(x) % 1024; lo = co_m[i]; hi = co_m[i+1];
    return lo + floor8((hi - lo) * w, 1024);
  endfunction

  function automatic string tag_of(logic [18:0] x);
    if (force_tag != "") return force_tag;
    if (x[18]) return "R5";
    if (x < 8) return "R1";
    if (x < 2048) return (x >= 2040) ? "R9" : "R2";
    return (x >= 19'd261120) ? "R9" : "R3";
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(bit v, logic [18:0] x);
    @(negedge clk);
    check("R6", int'(valid_o), int'(p1_v));
    if (p1_v) check(p1_t, int'(y_o), p1_e);
    p1_v = p0_v; p1_e = p0_e; p1_t = p0_t;
    p0_v = v; p0_e = v ? model(x) : 0; p0_t = tag_of(x);
    valid_i = v; x_i = x;
  endtask

  task automatic flush();
    step(0, '0);
    step(0, '0);
  endtask

  task automatic wr(logic [1:0] t, logic [8:0] a, int d);
    @(negedge clk);
    wr_en_i = 1'b1; wr_tbl_i = t; wr_addr_i = a; wr_data_i = 16'(d);
    if (t == 2'd3) max_m = d;
    else if (t == 2'd0 && a < 9) sf_m[a] = d;
    else if (t == 2'd1 && a < 257) fn_m[a] = d;
    else if (t == 2'd2 && a < 257) co_m[a] = d;
  endtask

  task automatic wr_end();
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R8", int'(valid_o), 0);
    check("R8", int'(y_o), 0);
    force_tag = "R8";
    step(1, 19'h40000);
    flush();
    force_tag = "";

    for (int i = 0; i < 9; i++) wr(2'd0, 9'(i), 100 + i * 911);
    for (int i = 0; i < 257; i++) wr(2'd1, 9'(i), (i * 40503 + 777) % 65536);
    for (int i = 0; i < 257; i++)
      wr(2'd2, 9'(i), (i % 3 == 0) ? 60000 - i * 97 : i * 131);
    wr(2'd3, 9'd0, 65535);
    wr_end();

    for (int x = 0; x < 4096; x++) step(1, 19'(x));
    for (int k = 2; k < 256; k++) begin
      step(1, 19'(k * 1024));
      step(1, 19'(k * 1024 + 1));
      step(1, 19'(k * 1024 + 513));
      step(1, 19'(k * 1024 + 1023));
    end
    step(1, 19'h3ffff);
    step(1, 19'h40000);
    step(1, 19'h43039);
    step(1, 19'h7ffff);
    for (int n = 0; n < 3000; n++) begin
      if (n % 16 == 0) step(1, 19'h40000 | 19'($urandom_range(0, 262143)));
      else step(1, 19'($urandom_range(0, 262143)));
    end
    flush();

    // falling interval with a rounding remainder: 5000 + floor(-4001*3/8) = 3499
    wr(2'd1, 9'd10, 5000);
    wr(2'd1, 9'd11, 999);
    wr_end();
    force_tag = "R4";
    step(1, 19'd83);
    flush();
    check("R4", model(19'd83), 3499);

    // out-of-range writes must not alias into any table; max ignores address
    wr(2'd0, 9'd9, 16'hdead);
    wr(2'd0, 9'd19, 16'hbeef);
    wr(2'd0, 9'd24, 16'h1234);
    wr(2'd1, 9'd257, 16'h0bad);
    wr(2'd1, 9'd300, 16'h0f0f);
    wr(2'd2, 9'd257, 16'h7777);
    wr(2'd2, 9'd511, 16'h3333);
    wr(2'd3, 9'd77, 12345);
    wr_end();
    force_tag = "R7";
    for (int x = 0; x < 16; x++) step(1, 19'(x));
    for (int x = 2040; x < 2048; x++) step(1, 19'(x));
    for (int x = 261120; x < 262144; x += 37) step(1, 19'(x));
    step(1, 19'h3ffff);
    step(1, 19'h40000);
    flush();
    force_tag = "";

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule